// File: doc/BRIEF.md
# Infrared Edge Interval Capture Unit

This block receives a demodulated infrared line and measures the time between its transitions. A programmable prescaler divides the system clock into a time tick. An interval counter accumulates ticks. On every edge of the kind that software selected, the running count is frozen into a readable field, the counter starts again from zero, and a level interrupt is raised.

Software reads the frozen interval together with the present line level. It then rebuilds the pulse/space train and decodes the remote-control protocol itself. No protocol matching is done in hardware. The mode field exists so that drivers can write the value they expect, but capture always works in raw mode.

Access goes through a simple register port with separate read and write strobes and a byte address. Read data is registered.

Top module: `irx_capture`

## Requirements
- R1: The rate register at address 0x10 holds a 12-bit value in bits 11:0 and resets to 0. The tick fires once every (rate + 1) clock cycles.
- R2: When two selected edges reach the detector D cycles apart, the second one stores floor((D-1)/(rate+1)) in the interval field, bits 28:16 of the control register at address 0x1C. The same edge restarts both the count and the prescaler from zero.
- R3: The interval count saturates at 8191 and does not wrap, so a gap longer than 8191 ticks reads as 8191.
- R4: The edge-select field, control bits 3:2, decodes as follows: 1 selects both edges, 2 selects falling edges only, 3 selects rising edges only. An edge that is not selected raises no interrupt and does not restart the count.
- R5: Edge-select value 0 stands for protocol-decoder events. Because no decoder is present, no edge ever raises the interrupt under this value.
- R6: The interrupt is a level output. A capture sets it. A read of the control register (0x1C) clears it, except when a capture happens in the same cycle, in which case the capture wins.
- R7: The enable bit is control bit 15. While it is 0, no edge is captured, no interrupt is raised, the count is held at zero, and the last interval is kept.
- R8: The soft-reset bit is control bit 0. While it is 1, the interval field, the count and the interrupt are held at zero and no edge is captured.
- R9: Bit 8 of the status register at address 0x18 gives the input level after a two-flop synchroniser.
- R10: The mode field, control bits 8:7, resets to 2 (raw) and reads back whatever was written. Its value has no effect on capture. After reset the control register reads 0x0000_0100.
- R11: Read data appears on the clock edge after the read strobe. Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ir_in | input | 1 | Asynchronous demodulated IR line |
| irq | output | 1 | Level interrupt, set on a capture |

## Verification
Some rules hold on every cycle and are checked by the assertions:
- a restart zeroes the count, and the interval field takes the count from the cycle before;
- a saturated count stays saturated until the next restart;
- while soft reset is set, both the interrupt and the interval are held at zero;
- the interrupt cannot rise when the block is disabled or the edge select is 0;
- a control read with no capture in that cycle clears the interrupt.

Other behaviour needs the bench's scenarios to show it. The exact interval formula across a sweep of rates and gaps, the saturation boundary, the edge-select filtering over a combined rise/fall/rise pattern, the synchronised status level, and the register read-back values are only visible that way.

// File: rtl/irx_pkg.sv
package irx_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_RATE = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h1C;

  localparam int B_SRST    = 0;
  localparam int B_SEL_LO  = 2;
  localparam int B_MODE_LO = 7;
  localparam int B_LEVEL   = 8;
  localparam int B_EN      = 15;
  localparam int B_IVL_LO  = 16;

  localparam logic [1:0] MODE_RAW = 2'd2;

  typedef enum logic [1:0] {
    SEL_DECODER = 2'd0,
    SEL_BOTH    = 2'd1,
    SEL_FALL    = 2'd2,
    SEL_RISE    = 2'd3
  } irq_sel_e;
endpackage

// File: rtl/irx_sync.sv
module irx_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= IDLE;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/irx_tick.sv
module irx_tick #(
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] pcnt;

  assign tick = (pcnt == rate) && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)        pcnt <= '0;
    else if (pcnt >= rate) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/irx_interval.sv
module irx_interval #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_clr,
  input  logic             ivl_clr,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] ivl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || cnt_clr)                  run_cnt <= '0;
    else if (restart)                    run_cnt <= '0;
    else if (tick && run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || ivl_clr) ivl <= '0;
    else if (restart)   ivl <= run_cnt;
  end
endmodule

// File: rtl/irx_capture.sv
module irx_capture
  import irx_pkg::*;
#(
  parameter int RATE_W      = 12,
  parameter int CNT_W       = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ir_in,
  output logic              irq
);
  logic [RATE_W-1:0] rate_q;
  irq_sel_e          sel_q;
  logic [1:0]        mode_q;
  logic              en_q, srst_q;
  logic              level, rise, fall, tick;
  logic              sel_hit, restart, irq_set, rd_ctrl;
  logic [CNT_W-1:0]  run_cnt, ivl;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  irx_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(ir_in), .level(level), .rise(rise), .fall(fall)
  );

  always_comb begin
    unique case (sel_q)
      SEL_BOTH: sel_hit = rise | fall;
      SEL_FALL: sel_hit = fall;
      SEL_RISE: sel_hit = rise;
      default:  sel_hit = 1'b0;
    endcase
  end

  assign restart = sel_hit && en_q && !srst_q;
  assign irq_set = restart;
  assign rd_ctrl = rd_en && (addr == OFF_CTRL);

  irx_tick #(.RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst(rst), .clr(srst_q || !en_q || restart), .rate(rate_q), .tick(tick)
  );

  irx_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst(rst), .cnt_clr(srst_q || !en_q), .ivl_clr(srst_q),
    .tick(tick), .restart(restart), .run_cnt(run_cnt), .ivl(ivl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      sel_q  <= SEL_DECODER;
      mode_q <= MODE_RAW;
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFF_RATE) rate_q <= wdata[RATE_W-1:0];
      if (addr == OFF_CTRL) begin
        srst_q <= wdata[B_SRST];
        sel_q  <= irq_sel_e'(wdata[B_SEL_LO +: 2]);
        mode_q <= wdata[B_MODE_LO +: 2];
        en_q   <= wdata[B_EN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) irq <= 1'b0;
    else if (irq_set)  irq <= 1'b1;
    else if (rd_ctrl)  irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      case (addr)
        OFF_RATE: rdata[RATE_W-1:0] <= rate_q;
        OFF_STAT: rdata[B_LEVEL]    <= level;
        OFF_CTRL: begin
          rdata[B_SRST]             <= srst_q;
          rdata[B_SEL_LO +: 2]      <= sel_q;
          rdata[B_MODE_LO +: 2]     <= mode_q;
          rdata[B_EN]               <= en_q;
          rdata[B_IVL_LO +: CNT_W]  <= ivl;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irx_capture_chk.sv
module irx_capture_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             irq_set,
  input logic             rd_ctrl,
  input logic             en_q,
  input logic             srst_q,
  input logic [1:0]       sel_q,
  input logic             restart,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] ivl
);
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (rst)
    restart |=> (run_cnt == '0));

  a_r2_latch_count: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ivl == $past(run_cnt)));

  a_r3_sat_hold: assert property (@(posedge clk) disable iff (rst)
    ((&run_cnt) && !restart && en_q && !srst_q) |=> (&run_cnt));

  a_r5_sel_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel_q == 2'd0 && !irq) |=> !irq);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !irq_set) |=> !irq);

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !irq) |=> !irq);

  a_r8_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!irq && ivl == '0));
endmodule

bind irx_capture irx_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .irq_set(irq_set), .rd_ctrl(rd_ctrl),
  .en_q(en_q), .srst_q(srst_q), .sel_q(sel_q), .restart(restart),
  .run_cnt(run_cnt), .ivl(ivl)
);

// File: tb/irx_capture_tb.sv
module irx_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ir_in = 1'b1;
  logic        irq;
  int          checks = 0, errors = 0;
  int          cyc = 0;
  logic [31:0] v;

  irx_capture u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ir_in(ir_in), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int sel, input bit en, input bit sr, input int mode);
    return (32'(en) << 15) | (32'(mode) << 7) | (32'(sel) << 2) | 32'(sr);
  endfunction

  function automatic logic [31:0] exp_ivl(input int d, input int r);
    int q = (d - 1) / (r + 1);
    return (q > 8191) ? 32'd8191 : 32'(q);
  endfunction

  function automatic logic [31:0] fld(input logic [31:0] w);
    return (w >> 16) & 32'h1FFF;
  endfunction

  initial begin
    int rates[4] = '{0, 1, 3, 9};
    int gaps[6]  = '{1, 2, 5, 17, 40, 123};
    int sat[3]   = '{8190, 8192, 9000};
    logic [31:0] keep;

    waitc(5);
    rst = 1'b0;
    @(negedge clk);

    chk("R6 irq after reset", {31'd0, irq}, 32'd0);
    rd(6'h1C, v); chk("R10 control reset value", v, 32'h0000_0100);
    rd(6'h10, v); chk("R1 rate reset value", v, 32'd0);
    rd(6'h04, v); chk("R11 unmapped address", v, 32'd0);

    // R9: synchronised level
    ir_in = 1'b0; waitc(3);
    rd(6'h18, v); chk("R9 status level low", v, 32'h0);
    ir_in = 1'b1; waitc(3);
    rd(6'h18, v); chk("R9 status level high", v, 32'h100);

    // R10: mode readback, capture unaffected by mode 0
    wr(6'h1C, ctl(1, 1, 0, 0));
    rd(6'h1C, v); chk("R10 mode readback", v, 32'h0000_8004);
    ir_in = ~ir_in; waitc(10); ir_in = ~ir_in; waitc(4);
    rd(6'h1C, v); chk("R10 capture in mode 0", fld(v), 32'd9);

    // R1 / R2 / R6: rate and gap sweep, both edges selected
    foreach (rates[i]) begin
      wr(6'h10, 32'(rates[i]));
      rd(6'h10, v); chk("R1 rate readback", v, 32'(rates[i]));
      wr(6'h1C, ctl(1, 1, 0, 2));
      foreach (gaps[j]) begin
        ir_in = ~ir_in; waitc(gaps[j]); ir_in = ~ir_in; waitc(4);
        chk("R6 irq set on capture", {31'd0, irq}, 32'd1);
        rd(6'h1C, v);
        chk($sformatf("R2 interval rate=%0d gap=%0d", rates[i], gaps[j]),
            fld(v), exp_ivl(gaps[j], rates[i]));
        chk("R6 irq cleared by read", {31'd0, irq}, 32'd0);
      end
    end

    // R3: saturation boundary at rate 0
    wr(6'h10, 32'd0);
    foreach (sat[k]) begin
      ir_in = ~ir_in; waitc(sat[k]); ir_in = ~ir_in; waitc(4);
      rd(6'h1C, v);
      chk($sformatf("R3 saturating interval gap=%0d", sat[k]), fld(v), exp_ivl(sat[k], 0));
    end

    // R4: rising only; falling edge neither interrupts nor restarts
    ir_in = 1'b0; waitc(4);
    wr(6'h1C, ctl(3, 1, 0, 2));
    ir_in = 1'b1; waitc(4);
    rd(6'h1C, v); waitc(15);
    ir_in = 1'b0; waitc(4);
    chk("R4 falling edge ignored under rise select", {31'd0, irq}, 32'd0);
    waitc(26);
    ir_in = 1'b1; waitc(4);
    chk("R4 rising edge interrupts", {31'd0, irq}, 32'd1);
    rd(6'h1C, v); chk("R4 interval spans ignored edge", fld(v), 32'd49);

    // R4: falling only; rising edge neither interrupts nor restarts
    wr(6'h1C, ctl(2, 1, 0, 2));
    ir_in = 1'b0; waitc(4);
    rd(6'h1C, v); waitc(7);
    ir_in = 1'b1; waitc(4);
    chk("R4 rising edge ignored under fall select", {31'd0, irq}, 32'd0);
    waitc(9);
    ir_in = 1'b0; waitc(4);
    chk("R4 falling edge interrupts", {31'd0, irq}, 32'd1);
    rd(6'h1C, v); chk("R4 interval under fall select", fld(v), 32'd24);
    keep = fld(v);

    // R5: select 0 never interrupts
    wr(6'h1C, ctl(0, 1, 0, 2));
    ir_in = ~ir_in; waitc(6); ir_in = ~ir_in; waitc(6);
    chk("R5 no irq with select 0", {31'd0, irq}, 32'd0);
    rd(6'h1C, v); chk("R5 interval untouched with select 0", fld(v), keep);

    // R7: disabled
    wr(6'h1C, ctl(1, 0, 0, 2));
    ir_in = ~ir_in; waitc(8); ir_in = ~ir_in; waitc(6);
    chk("R7 no irq when disabled", {31'd0, irq}, 32'd0);
    rd(6'h1C, v); chk("R7 interval kept when disabled", fld(v), keep);

    // R8: soft reset
    wr(6'h1C, ctl(1, 1, 0, 2));
    ir_in = ~ir_in; waitc(4);
    chk("R8 precondition irq set", {31'd0, irq}, 32'd1);
    wr(6'h1C, ctl(1, 1, 1, 2));
    waitc(1);
    chk("R8 irq cleared by soft reset", {31'd0, irq}, 32'd0);
    ir_in = ~ir_in; waitc(6);
    chk("R8 no capture during soft reset", {31'd0, irq}, 32'd0);
    rd(6'h1C, v); chk("R8 interval cleared by soft reset", fld(v), 32'd0);
    wr(6'h1C, ctl(1, 1, 0, 2));
    ir_in = ~ir_in; waitc(20); ir_in = ~ir_in; waitc(4);
    rd(6'h1C, v); chk("R8 capture resumes after soft reset", fld(v), 32'd19);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule